// File: doc/BRIEF.md
# Floating-Point and Vector State Save Sequencer

This block turns a one-cycle start request into the sequence of memory writes that stores the floating-point unit state and the vector register state as a fixed-layout save image. The image sits at a caller-supplied base address, which must be aligned to 64 bytes. Two masks select what is stored. A requested-component mask comes with the request, and an enabled-component mask comes from control state. A component is stored only when both masks allow it. Two mode flags shape the image. The operand-size flag chooses between wide and split pointer formats. The long-mode flag decides whether the upper half of the vector register file is stored.

The block fetches state through narrow register-file read ports: one index selects a floating-point stack entry, and another selects a vector register. Scalar control values arrive on plain inputs. Before storing anything, the block reads the 64-bit component bitmap that sits 512 bytes into the image. It ORs in the components it stores and always writes the bitmap back. Every write is one 16-byte line with a per-byte enable mask, and it is offered under a valid/ready handshake. A separate read request port, with its own response strobe, fetches the bitmap. The block ends each request with a one-cycle completion pulse or a one-cycle fault pulse.

Top module: `save_seq`

## Requirements
- R1: A start whose base address has any of its low six bits set produces a one-cycle `fault` pulse on the next cycle. That request issues no read and no write.
- R2: The floating-point component (mask bit 0) is stored only when bit 0 is set in both `en_mask` and `req_mask`. The vector component (mask bit 1) is stored only when bit 1 is set in both masks. Bytes of a component that is not stored are never written.
- R3: The first line of the image holds the control word in bytes 0-1, the status word in bytes 2-3, the abridged tag in byte 4, a zero in byte 5 and the last opcode in bytes 6-7.
- R4: With `op64` high, bytes 8-15 hold the 64-bit instruction pointer and bytes 16-23 hold the 64-bit data pointer. With `op64` low, the layout is: instruction offset (low 32 bits) in bytes 8-11, code selector in bytes 12-13, zeros in bytes 14-15, data offset (low 32 bits) in bytes 16-19, data selector in bytes 20-21 and zeros in bytes 22-23.
- R5: Stack entry i (0 to 7) is stored at offset 32+16*i. Bytes 0-7 of the slot hold the 64-bit fraction, bytes 8-9 hold the sign/exponent, and bytes 10-15 are zero.
- R6: Storing the floating-point component never writes bytes 24-31 of the image; its data-pointer write enables only bytes 16-23.
- R7: When the vector component is stored, the vector control/status word goes to bytes 24-27 and its supported-bits mask to bytes 28-31. Vector register i goes to offset 160+16*i, for i in 0-7, and also for i in 8-15 when `long_mode` is high.
- R8: Every aligned request reads the 64-bit bitmap at base+512 first. It then writes back that value ORed with the bit of each stored component, with byte enables 0x00FF at line offset 512, even when nothing is stored.
- R9: Each write is a 16-byte-aligned address with a nonzero byte-enable mask. Address, enables and data stay unchanged while `wr_valid` is high and `wr_ready` is low.
- R10: `done` is high for exactly one cycle, the cycle after the bitmap write is accepted. `done` and `fault` are never high together, and both are low after reset.
- R11: Writes are issued in this order: the first floating-point line, the data-pointer half line, stack slots 0 to 7, the vector control half line, vector registers in ascending order, and the bitmap.
- R12: A start pulse that arrives while a request is in progress has no effect on that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to store state |
| base_addr | input | ADDR_W | Byte address of the save image |
| req_mask | input | 2 | Components requested (bit 0 float, bit 1 vector) |
| en_mask | input | 2 | Components enabled by control state |
| op64 | input | 1 | 64-bit operand size: wide pointer format |
| long_mode | input | 1 | Long mode: store vector registers 8-15 |
| fpu_ctrl | input | 16 | Floating-point control word |
| fpu_stat | input | 16 | Floating-point status word |
| fpu_tag | input | 8 | Abridged tag byte |
| fpu_opc | input | 16 | Last opcode |
| fpu_ip | input | 64 | Last instruction pointer |
| fpu_cs | input | 16 | Last code selector |
| fpu_dp | input | 64 | Last data pointer |
| fpu_ds | input | 16 | Last data selector |
| stk_idx | output | log2(NUM_STK) | Stack register read index |
| stk_frac | input | 64 | Fraction of the indexed stack entry |
| stk_exp | input | 16 | Sign/exponent of the indexed stack entry |
| vec_csr | input | 32 | Vector control/status word |
| vec_csr_mask | input | 32 | Supported-bits mask of the vector control word |
| vreg_idx | output | log2(NUM_VREG) | Vector register read index |
| vreg_data | input | 128 | Indexed vector register |
| rd_valid | output | 1 | Bitmap read request |
| rd_ready | input | 1 | Read request accepted |
| rd_addr | output | ADDR_W | Bitmap read address |
| rd_rvalid | input | 1 | Read response strobe |
| rd_rdata | input | 64 | Read response data |
| wr_valid | output | 1 | Write offered |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | ADDR_W | 16-byte-aligned write address |
| wr_be | output | 16 | Byte enables of the write line |
| wr_data | output | 128 | Write line data, byte k in bits 8k+7:8k |
| done | output | 1 | Request completed |
| fault | output | 1 | General-protection fault on misaligned base |

## Verification
The bench builds the block with its default parameters: eight stack entries, sixteen vector registers, eight of them stored outside long mode, and 32-bit addresses. With these values the full image of 528 bytes can be rebuilt byte by byte. The bench sweeps every combination of the two 2-bit masks and both mode flags, which covers each branch of component selection, both pointer formats and both vector register counts. Write and read acceptance stall on a pseudo-random pattern, so the write ordering and the hold behaviour are exercised under back-pressure. Separate runs cover several misaligned bases and start pulses that arrive during a busy request.

// File: rtl/save_seq_pkg.sv
package save_seq_pkg;

    // image offsets are fixed by the layout, independent of parameters
    localparam int OFF_W      = 10;
    localparam int LINE_BYTES = 16;
    localparam int LINE_BITS  = LINE_BYTES * 8;

    localparam int COMP_FP  = 0;
    localparam int COMP_VEC = 1;
    localparam int NUM_COMP = 2;

    localparam logic [OFF_W-1:0] OFF_FP_HEAD   = 10'd0;
    localparam logic [OFF_W-1:0] OFF_FP_DPTR   = 10'd16;
    localparam logic [OFF_W-1:0] OFF_STK_BASE  = 10'd32;
    localparam logic [OFF_W-1:0] OFF_VEC_CTL   = 10'd16;
    localparam logic [OFF_W-1:0] OFF_VREG_BASE = 10'd160;
    localparam logic [OFF_W-1:0] OFF_BITMAP    = 10'd512;

    localparam logic [LINE_BYTES-1:0] BE_FULL  = 16'hFFFF;
    localparam logic [LINE_BYTES-1:0] BE_LOW8  = 16'h00FF;
    localparam logic [LINE_BYTES-1:0] BE_HIGH8 = 16'hFF00;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_MAP_RD,
        ST_MAP_WAIT,
        ST_FP_HEAD,
        ST_FP_DPTR,
        ST_FP_STK,
        ST_VEC_CTL,
        ST_VEC_REG,
        ST_MAP_WR,
        ST_DONE,
        ST_FAULT
    } seq_state_e;

    typedef struct packed {
        logic [OFF_W-1:0]      off;
        logic [LINE_BYTES-1:0] be;
        logic [LINE_BITS-1:0]  data;
    } beat_t;

    typedef struct packed {
        logic [15:0] ctrl;
        logic [15:0] stat;
        logic [7:0]  tag;
        logic [15:0] opc;
        logic [63:0] ip;
        logic [15:0] cs;
        logic [63:0] dp;
        logic [15:0] ds;
    } fp_ctx_t;

    // control/status words, tag, opcode, then the instruction pointer
    function automatic logic [LINE_BITS-1:0] fp_head_line(fp_ctx_t c, logic wide);
        logic [63:0] ptr;
        ptr = wide ? c.ip : {16'h0000, c.cs, c.ip[31:0]};
        return {ptr, c.opc, 8'h00, c.tag, c.stat, c.ctrl};
    endfunction

    // data pointer only: the upper half belongs to the vector component
    function automatic logic [LINE_BITS-1:0] fp_dptr_line(fp_ctx_t c, logic wide);
        logic [63:0] ptr;
        ptr = wide ? c.dp : {16'h0000, c.ds, c.dp[31:0]};
        return {64'h0, ptr};
    endfunction

    function automatic logic [LINE_BITS-1:0] stack_line(logic [63:0] frac, logic [15:0] sexp);
        return {48'h0, sexp, frac};
    endfunction

    function automatic logic [LINE_BITS-1:0] vec_ctl_line(logic [31:0] csr, logic [31:0] msk);
        return {msk, csr, 64'h0};
    endfunction

    function automatic logic [OFF_W-1:0] slot_off(logic [OFF_W-1:0] base, logic [OFF_W-5:0] idx);
        return base + {idx, 4'b0000};
    endfunction

endpackage

// File: rtl/save_beat_build.sv
module save_beat_build
    import save_seq_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  seq_state_e             state,
    input  logic [IDX_W-1:0]       idx,
    input  logic                   wide,
    input  logic [NUM_COMP-1:0]    stored,
    input  fp_ctx_t                fp,
    input  logic [63:0]            stk_frac,
    input  logic [15:0]            stk_exp,
    input  logic [31:0]            vec_csr,
    input  logic [31:0]            vec_csr_mask,
    input  logic [LINE_BITS-1:0]   vreg_data,
    input  logic [63:0]            map_q,
    output beat_t                  beat
);

    localparam int SLOT_W = OFF_W - 4;

    logic [SLOT_W-1:0] slot;
    logic [63:0]       map_out;

    assign slot    = SLOT_W'(idx);
    assign map_out = map_q | 64'(stored);

    always_comb begin
        beat = '0;
        unique case (state)
            ST_FP_HEAD: begin
                beat.off  = OFF_FP_HEAD;
                beat.be   = BE_FULL;
                beat.data = fp_head_line(fp, wide);
            end
            ST_FP_DPTR: begin
                beat.off  = OFF_FP_DPTR;
                beat.be   = BE_LOW8;
                beat.data = fp_dptr_line(fp, wide);
            end
            ST_FP_STK: begin
                beat.off  = slot_off(OFF_STK_BASE, slot);
                beat.be   = BE_FULL;
                beat.data = stack_line(stk_frac, stk_exp);
            end
            ST_VEC_CTL: begin
                beat.off  = OFF_VEC_CTL;
                beat.be   = BE_HIGH8;
                beat.data = vec_ctl_line(vec_csr, vec_csr_mask);
            end
            ST_VEC_REG: begin
                beat.off  = slot_off(OFF_VREG_BASE, slot);
                beat.be   = BE_FULL;
                beat.data = vreg_data;
            end
            ST_MAP_WR: begin
                beat.off  = OFF_BITMAP;
                beat.be   = BE_LOW8;
                beat.data = {64'h0, map_out};
            end
            default: beat = '0;
        endcase
    end

endmodule

// File: rtl/save_seq_fsm.sv
module save_seq_fsm
    import save_seq_pkg::*;
#(
    parameter int ADDR_W          = 32,
    parameter int ALIGN_LOG2      = 6,
    parameter int NUM_STK         = 8,
    parameter int NUM_VREG        = 16,
    parameter int NUM_VREG_NARROW = 8,
    parameter int IDX_W           = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic [ADDR_W-1:0]   base_addr,
    input  logic [NUM_COMP-1:0] req_mask,
    input  logic [NUM_COMP-1:0] en_mask,
    input  logic                op64,
    input  logic                long_mode,
    input  logic                wr_ready,
    input  logic                rd_ready,
    input  logic                rd_rvalid,
    input  logic [63:0]         rd_rdata,
    output seq_state_e          state,
    output logic [IDX_W-1:0]    idx,
    output logic [ADDR_W-1:0]   base_q,
    output logic                wide_q,
    output logic [NUM_COMP-1:0] stored_q,
    output logic [63:0]         map_q
);

    localparam logic [IDX_W-1:0] STK_LAST    = IDX_W'(NUM_STK - 1);
    localparam logic [IDX_W-1:0] VREG_LAST   = IDX_W'(NUM_VREG - 1);
    localparam logic [IDX_W-1:0] VREG_LAST_N = IDX_W'(NUM_VREG_NARROW - 1);

    logic long_q;
    logic misaligned;
    logic [IDX_W-1:0] vreg_last;
    seq_state_e after_map;
    seq_state_e after_stk;

    assign misaligned = |base_addr[ALIGN_LOG2-1:0];
    assign vreg_last  = long_q ? VREG_LAST : VREG_LAST_N;
    assign after_map  = stored_q[COMP_FP]  ? ST_FP_HEAD :
                        stored_q[COMP_VEC] ? ST_VEC_CTL : ST_MAP_WR;
    assign after_stk  = stored_q[COMP_VEC] ? ST_VEC_CTL : ST_MAP_WR;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            idx      <= '0;
            base_q   <= '0;
            wide_q   <= 1'b0;
            long_q   <= 1'b0;
            stored_q <= '0;
            map_q    <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (start) begin
                    base_q   <= base_addr;
                    wide_q   <= op64;
                    long_q   <= long_mode;
                    stored_q <= req_mask & en_mask;
                    idx      <= '0;
                    state    <= misaligned ? ST_FAULT : ST_MAP_RD;
                end
                ST_MAP_RD:   if (rd_ready) state <= ST_MAP_WAIT;
                ST_MAP_WAIT: if (rd_rvalid) begin
                    map_q <= rd_rdata;
                    state <= after_map;
                end
                ST_FP_HEAD:  if (wr_ready) state <= ST_FP_DPTR;
                ST_FP_DPTR:  if (wr_ready) begin
                    idx   <= '0;
                    state <= ST_FP_STK;
                end
                ST_FP_STK:   if (wr_ready) begin
                    if (idx == STK_LAST) begin
                        idx   <= '0;
                        state <= after_stk;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_VEC_CTL:  if (wr_ready) begin
                    idx   <= '0;
                    state <= ST_VEC_REG;
                end
                ST_VEC_REG:  if (wr_ready) begin
                    if (idx == vreg_last) begin
                        idx   <= '0;
                        state <= ST_MAP_WR;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                ST_MAP_WR:   if (wr_ready) state <= ST_DONE;
                ST_DONE:     state <= ST_IDLE;
                ST_FAULT:    state <= ST_IDLE;
                default:     state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/save_seq.sv
module save_seq
    import save_seq_pkg::*;
#(
    parameter int ADDR_W          = 32,
    parameter int ALIGN_LOG2      = 6,
    parameter int NUM_STK         = 8,
    parameter int NUM_VREG        = 16,
    parameter int NUM_VREG_NARROW = 8
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic [ADDR_W-1:0]             base_addr,
    input  logic [1:0]                    req_mask,
    input  logic [1:0]                    en_mask,
    input  logic                          op64,
    input  logic                          long_mode,
    input  logic [15:0]                   fpu_ctrl,
    input  logic [15:0]                   fpu_stat,
    input  logic [7:0]                    fpu_tag,
    input  logic [15:0]                   fpu_opc,
    input  logic [63:0]                   fpu_ip,
    input  logic [15:0]                   fpu_cs,
    input  logic [63:0]                   fpu_dp,
    input  logic [15:0]                   fpu_ds,
    output logic [$clog2(NUM_STK)-1:0]    stk_idx,
    input  logic [63:0]                   stk_frac,
    input  logic [15:0]                   stk_exp,
    input  logic [31:0]                   vec_csr,
    input  logic [31:0]                   vec_csr_mask,
    output logic [$clog2(NUM_VREG)-1:0]   vreg_idx,
    input  logic [127:0]                  vreg_data,
    output logic                          rd_valid,
    input  logic                          rd_ready,
    output logic [ADDR_W-1:0]             rd_addr,
    input  logic                          rd_rvalid,
    input  logic [63:0]                   rd_rdata,
    output logic                          wr_valid,
    input  logic                          wr_ready,
    output logic [ADDR_W-1:0]             wr_addr,
    output logic [15:0]                   wr_be,
    output logic [127:0]                  wr_data,
    output logic                          done,
    output logic                          fault
);

    localparam int STK_W  = $clog2(NUM_STK);
    localparam int VREG_W = $clog2(NUM_VREG);
    localparam int IDX_W  = (VREG_W > STK_W) ? VREG_W : STK_W;

    seq_state_e          state;
    logic [IDX_W-1:0]    idx;
    logic [ADDR_W-1:0]   base_q;
    logic                wide_q;
    logic [NUM_COMP-1:0] stored_q;
    logic [63:0]         map_q;
    logic                busy;
    fp_ctx_t             fp;
    beat_t               beat;

    assign fp = '{ctrl: fpu_ctrl, stat: fpu_stat, tag: fpu_tag, opc: fpu_opc,
                  ip: fpu_ip, cs: fpu_cs, dp: fpu_dp, ds: fpu_ds};

    save_seq_fsm #(
        .ADDR_W          (ADDR_W),
        .ALIGN_LOG2      (ALIGN_LOG2),
        .NUM_STK         (NUM_STK),
        .NUM_VREG        (NUM_VREG),
        .NUM_VREG_NARROW (NUM_VREG_NARROW),
        .IDX_W           (IDX_W)
    ) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .base_addr (base_addr),
        .req_mask  (req_mask),
        .en_mask   (en_mask),
        .op64      (op64),
        .long_mode (long_mode),
        .wr_ready  (wr_ready),
        .rd_ready  (rd_ready),
        .rd_rvalid (rd_rvalid),
        .rd_rdata  (rd_rdata),
        .state     (state),
        .idx       (idx),
        .base_q    (base_q),
        .wide_q    (wide_q),
        .stored_q  (stored_q),
        .map_q     (map_q)
    );

    save_beat_build #(
        .IDX_W (IDX_W)
    ) u_build (
        .state        (state),
        .idx          (idx),
        .wide         (wide_q),
        .stored       (stored_q),
        .fp           (fp),
        .stk_frac     (stk_frac),
        .stk_exp      (stk_exp),
        .vec_csr      (vec_csr),
        .vec_csr_mask (vec_csr_mask),
        .vreg_data    (vreg_data),
        .map_q        (map_q),
        .beat         (beat)
    );

    assign busy     = (state != ST_IDLE);
    assign stk_idx  = idx[STK_W-1:0];
    assign vreg_idx = idx[VREG_W-1:0];

    assign rd_valid = (state == ST_MAP_RD);
    assign rd_addr  = base_q + ADDR_W'(OFF_BITMAP);

    assign wr_valid = (state inside {ST_FP_HEAD, ST_FP_DPTR, ST_FP_STK,
                                     ST_VEC_CTL, ST_VEC_REG, ST_MAP_WR});
    assign wr_addr  = base_q + ADDR_W'(beat.off);
    assign wr_be    = beat.be;
    assign wr_data  = beat.data;

    assign done  = (state == ST_DONE);
    assign fault = (state == ST_FAULT);

endmodule

// File: rtl/save_seq_chk.sv
module save_seq_chk #(
    parameter int ADDR_W     = 32,
    parameter int ALIGN_LOG2 = 6
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  start,
    input logic [ALIGN_LOG2-1:0] base_lo,
    input logic                  busy,
    input logic                  rd_valid,
    input logic                  wr_valid,
    input logic                  wr_ready,
    input logic [ADDR_W-1:0]     wr_addr,
    input logic [15:0]           wr_be,
    input logic                  done,
    input logic                  fault
);

    assert_misalign_faults_R1: assert property (@(posedge clk) disable iff (rst)
        (!busy && start && base_lo != '0) |=> fault);

    assert_fault_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        fault |-> (!wr_valid && !rd_valid));

    assert_fault_then_idle_R1: assert property (@(posedge clk) disable iff (rst)
        fault |=> !wr_valid);

    assert_write_held_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_be)));

    assert_write_line_R9: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> (wr_addr[3:0] == 4'h0 && wr_be != 16'h0));

    assert_done_after_accept_R10: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(wr_valid && wr_ready));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_fault_excl_R10: assert property (@(posedge clk) disable iff (rst)
        !(done && fault));

endmodule

bind save_seq save_seq_chk #(
    .ADDR_W     (ADDR_W),
    .ALIGN_LOG2 (ALIGN_LOG2)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .base_lo  (base_addr[ALIGN_LOG2-1:0]),
    .busy     (busy),
    .rd_valid (rd_valid),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_be    (wr_be),
    .done     (done),
    .fault    (fault)
);

// File: tb/save_seq_bench.sv
module save_seq_bench;

    localparam int CLK_PERIOD = 10;
    localparam int IMG_BYTES  = 528;
    localparam int MAX_CYC    = 190000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [31:0]  base_addr = '0;
    logic [1:0]   req_mask = '0, en_mask = '0;
    logic         op64 = 1'b0, long_mode = 1'b0;
    logic [15:0]  fpu_ctrl, fpu_stat, fpu_opc, fpu_cs, fpu_ds;
    logic [7:0]   fpu_tag;
    logic [63:0]  fpu_ip, fpu_dp;
    logic [2:0]   stk_idx;
    logic [63:0]  stk_frac;
    logic [15:0]  stk_exp;
    logic [31:0]  vec_csr, vec_csr_mask;
    logic [3:0]   vreg_idx;
    logic [127:0] vreg_data;
    logic         rd_valid, rd_ready = 1'b0;
    logic [31:0]  rd_addr;
    logic         rd_rvalid = 1'b0;
    logic [63:0]  rd_rdata = '0;
    logic         wr_valid, wr_ready = 1'b0;
    logic [31:0]  wr_addr;
    logic [15:0]  wr_be;
    logic [127:0] wr_data;
    logic         done, fault;

    int seed = 0;
    int checks = 0;
    int fails = 0;
    int cyc = 0;

    function automatic logic [63:0] frac_of(int s, int i);
        return {16'hFACE, 8'(s), 8'(i), 32'h1357_9BDF ^ 32'(s * 977)};
    endfunction
    function automatic logic [15:0] exp_of(int s, int i);
        return {4'h4, 4'(i), 8'(s)};
    endfunction
    function automatic logic [127:0] vreg_of(int s, int i);
        return {32'(s * 31 + i), 32'hDEAD_0000 | 32'(i), 32'(i * i + 7), 32'hC0DE_0000 + 32'(s)};
    endfunction

    assign stk_frac  = frac_of(seed, int'(stk_idx));
    assign stk_exp   = exp_of(seed, int'(stk_idx));
    assign vreg_data = vreg_of(seed, int'(vreg_idx));

    save_seq u_save_seq (
        .clk(clk), .rst(rst), .start(start), .base_addr(base_addr),
        .req_mask(req_mask), .en_mask(en_mask), .op64(op64), .long_mode(long_mode),
        .fpu_ctrl(fpu_ctrl), .fpu_stat(fpu_stat), .fpu_tag(fpu_tag), .fpu_opc(fpu_opc),
        .fpu_ip(fpu_ip), .fpu_cs(fpu_cs), .fpu_dp(fpu_dp), .fpu_ds(fpu_ds),
        .stk_idx(stk_idx), .stk_frac(stk_frac), .stk_exp(stk_exp),
        .vec_csr(vec_csr), .vec_csr_mask(vec_csr_mask),
        .vreg_idx(vreg_idx), .vreg_data(vreg_data),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
        .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
        .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_be(wr_be), .wr_data(wr_data), .done(done), .fault(fault)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // observed image and events of the current request
    logic [7:0]  act_b [IMG_BYTES];
    logic        act_w [IMG_BYTES];
    logic [7:0]  exp_b [IMG_BYTES];
    logic        exp_w [IMG_BYTES];
    int          act_seq [32];
    int          exp_seq [32];
    int          n_act, n_exp;
    int          n_rd, rd_bad, n_done, n_fault, hold_err, range_err;
    logic [31:0] mon_base;
    logic        rd_fire_prev = 1'b0;
    logic        hold_pend = 1'b0;
    logic [31:0] h_addr;
    logic [15:0] h_be;
    logic [127:0] h_data;
    logic [15:0] lfsr = 16'hACE1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > MAX_CYC) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, MAX_CYC);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
        if (hold_pend && !(wr_valid && wr_addr == h_addr && wr_be == h_be && wr_data == h_data))
            hold_err++;
        // handshake values seen here are those used at the next rising edge
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        wr_ready = lfsr[0] | lfsr[3];
        rd_ready = lfsr[5] | lfsr[1];
        rd_rvalid = rd_fire_prev;
        rd_fire_prev = rd_valid && rd_ready;
        if (rd_valid && rd_ready) begin
            n_rd++;
            if (rd_addr != mon_base + 32'd512) rd_bad++;
        end
        hold_pend = wr_valid && !wr_ready;
        h_addr = wr_addr;
        h_be = wr_be;
        h_data = wr_data;
        if (wr_valid && wr_ready) begin
            int off;
            off = int'(wr_addr - mon_base);
            if (wr_addr[3:0] != 4'h0 || off < 0 || off + 16 > IMG_BYTES) begin
                range_err++;
            end else begin
                for (int b = 0; b < 16; b++) begin
                    if (wr_be[b]) begin
                        act_b[off + b] = wr_data[8 * b +: 8];
                        act_w[off + b] = 1'b1;
                    end
                end
            end
            if (n_act < 32) act_seq[n_act] = off;
            n_act++;
        end
        if (done) n_done++;
        if (fault) n_fault++;
    end

    task automatic put(input int off, input int n, input logic [127:0] v);
        for (int b = 0; b < n; b++) begin
            exp_b[off + b] = v[8 * b +: 8];
            exp_w[off + b] = 1'b1;
        end
    endtask

    task automatic push_seq(input int off);
        exp_seq[n_exp] = off;
        n_exp++;
    endtask

    function automatic string tag_of(int off);
        if (off < 8) return "R3";
        if (off < 24) return "R4";
        if (off < 32) return "R6 R7";
        if (off < 160) return "R5";
        if (off < 512) return "R7";
        return "R8";
    endfunction

    task automatic clear_run(input logic [31:0] base);
        for (int i = 0; i < IMG_BYTES; i++) begin
            act_b[i] = 8'h00; act_w[i] = 1'b0; exp_b[i] = 8'h00; exp_w[i] = 1'b0;
        end
        n_act = 0; n_exp = 0; n_rd = 0; rd_bad = 0; n_done = 0; n_fault = 0;
        hold_err = 0; range_err = 0;
        mon_base = base;
    endtask

    task automatic run_save(input logic [1:0] rq, input logic [1:0] en,
                            input logic o64, input logic lm, input int s, input bit poke);
        logic [31:0] base;
        logic [63:0] map_in;
        logic        sv_fp, sv_vec;
        int          k;
        @(negedge clk);
        seed = s;
        base = 32'h0000_4000 + 32'(s) * 32'h800;
        fpu_ctrl = 16'h1000 + 16'(s); fpu_stat = 16'h2100 + 16'(s);
        fpu_tag = 8'h30 + 8'(s);      fpu_opc = 16'h0400 + 16'(s);
        fpu_ip = {32'hA1A2_A3A4, 32'hB100_0000 + 32'(s)};  fpu_cs = 16'h0C00 + 16'(s);
        fpu_dp = {32'hD1D2_D3D4, 32'hE100_0000 + 32'(s)};  fpu_ds = 16'h0D00 + 16'(s);
        vec_csr = 32'h0000_1F80 + 32'(s); vec_csr_mask = 32'h0000_FFFF;
        map_in = 64'hC3C3_0000_1234_5600 | 64'((s * 7) & 3);
        rd_rdata = map_in;
        clear_run(base);
        sv_fp = rq[0] & en[0];
        sv_vec = rq[1] & en[1];
        if (sv_fp) begin
            put(0, 2, 128'(fpu_ctrl)); put(2, 2, 128'(fpu_stat));
            put(4, 1, 128'(fpu_tag)); put(5, 1, 128'h0); put(6, 2, 128'(fpu_opc));
            if (o64) begin
                put(8, 8, 128'(fpu_ip)); put(16, 8, 128'(fpu_dp));
            end else begin
                put(8, 4, 128'(fpu_ip[31:0])); put(12, 2, 128'(fpu_cs)); put(14, 2, 128'h0);
                put(16, 4, 128'(fpu_dp[31:0])); put(20, 2, 128'(fpu_ds)); put(22, 2, 128'h0);
            end
            push_seq(0); push_seq(16);
            for (int i = 0; i < 8; i++) begin
                put(32 + 16 * i, 8, 128'(frac_of(s, i)));
                put(40 + 16 * i, 2, 128'(exp_of(s, i)));
                put(42 + 16 * i, 6, 128'h0);
                push_seq(32 + 16 * i);
            end
        end
        if (sv_vec) begin
            put(24, 4, 128'(vec_csr)); put(28, 4, 128'(vec_csr_mask));
            push_seq(16);
            for (int i = 0; i < (lm ? 16 : 8); i++) begin
                put(160 + 16 * i, 16, vreg_of(s, i));
                push_seq(160 + 16 * i);
            end
        end
        put(512, 8, 128'(map_in | {62'h0, sv_vec, sv_fp}));
        push_seq(512);
        base_addr = base; req_mask = rq; en_mask = en; op64 = o64; long_mode = lm;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (2) @(negedge clk);
            base_addr = base ^ 32'h0000_0043;
            req_mask = ~rq; en_mask = 2'b11; op64 = ~o64; long_mode = ~lm;
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        k = 0;
        while (n_done == 0 && n_fault == 0 && k < 4000) begin
            @(negedge clk);
            k++;
        end
        repeat (3) @(negedge clk);
        for (int ln = 0; ln < IMG_BYTES / 16; ln++) begin
            logic [127:0] av, ev;
            logic [15:0]  aw, ew;
            for (int b = 0; b < 16; b++) begin
                av[8 * b +: 8] = act_b[16 * ln + b]; ev[8 * b +: 8] = exp_b[16 * ln + b];
                aw[b] = act_w[16 * ln + b];          ew[b] = exp_w[16 * ln + b];
            end
            if (ln < 32 || ln == 32)
                check(av == ev && aw == ew, tag_of(16 * ln),
                      $sformatf("R2 image line %0d mask rq=%b en=%b o64=%b lm=%b", 16 * ln, rq, en, o64, lm),
                      {aw, av[111:0]}, {ew, ev[111:0]});
        end
        begin
            bit same;
            same = (n_act == n_exp);
            for (int i = 0; i < n_exp && i < 32; i++) if (act_seq[i] != exp_seq[i]) same = 1'b0;
            check(same, "R11", "write order", 128'(n_act), 128'(n_exp));
        end
        check(n_rd == 1 && rd_bad == 0, "R8", "bitmap read count/address", 128'(n_rd), 128'd1);
        check(hold_err == 0 && range_err == 0, "R9", "write hold and alignment", 128'(hold_err + range_err), 128'd0);
        check(n_done == 1 && n_fault == 0, "R10", "one done pulse, no fault", {64'(n_done), 64'(n_fault)}, {64'd1, 64'd0});
        if (poke)
            check(n_done == 1 && n_act == n_exp && range_err == 0, "R12", "start while busy ignored",
                  128'(n_act), 128'(n_exp));
    endtask

    task automatic run_misaligned(input int lo, input int s);
        @(negedge clk);
        clear_run(32'h0002_0000 + 32'(s) * 32'h100 + 32'(lo));
        base_addr = mon_base; req_mask = 2'b11; en_mask = 2'b11;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (12) @(negedge clk);
        check(n_fault == 1 && n_done == 0, "R1", $sformatf("fault pulse for low bits %0d", lo),
              {64'(n_fault), 64'(n_done)}, {64'd1, 64'd0});
        check(n_act == 0 && n_rd == 0, "R1", "no access on fault", {64'(n_act), 64'(n_rd)}, 128'd0);
    endtask

    initial begin
        fpu_ctrl = '0; fpu_stat = '0; fpu_tag = '0; fpu_opc = '0;
        fpu_ip = '0; fpu_cs = '0; fpu_dp = '0; fpu_ds = '0;
        vec_csr = '0; vec_csr_mask = '0;
        clear_run(32'h0);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!done && !fault && !wr_valid && !rd_valid, "R10", "reset outputs idle",
              128'({done, fault, wr_valid, rd_valid}), 128'd0);
        for (int m = 0; m < 64; m++) begin
            run_save(m[1:0], m[3:2], m[4], m[5], m + 1, (m % 5) == 2);
        end
        run_misaligned(1, 1);
        run_misaligned(8, 2);
        run_misaligned(16, 3);
        run_misaligned(32, 4);
        run_misaligned(63, 5);
        // aligned request right after faults still completes
        run_save(2'b11, 2'b11, 1'b1, 1'b1, 70, 1'b0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule